// File: doc/BRIEF.md
# Chainable Performance Event Counter Bank

This block is a bank of programmable 32-bit performance counters that sits on a simple 32-bit register bus. Each counter has its own event selector. It picks one line of a wide event input, and the counter adds one on every clock edge at which the bank is enabled and that line is high. A per-counter option makes a counter count every enabled clock cycle instead of its event. Counters are grouped in adjacent even/odd pairs. Setting one control bit per pair turns the pair into a single 64-bit counter: the even counter holds the low word, and the odd counter takes the carry.

Software starts and stops the whole bank with one enable bit. It zeroes every counter with a self-clearing clear bit. It can also preload any counter through that counter's value register. Values can be read while the bank is counting. Reading the low word of a joined pair captures the high word at the same instant, so a 64-bit value read as two 32-bit reads is consistent.

Top module: `perf_counter_bank`

## Requirements
- R1: After reset, every counter, event selector, count-clock bit, join bit and the enable bit are zero, and every read returns zero.
- R2: Counter i increments by exactly one on each clock edge at which the bank is enabled and the event line selected by its selector is high. The selector is written and read at byte offset 0x40 + 4*i; its low log2(NUM_EVT) bits are used, and the upper bits read as zero.
- R3: The control register sits at offset 0x0, and its bit 30 is the bank enable. While it is 0, no counter changes except through clear or preload. The bit reads back as written.
- R4: Writing control bit 28 as 1 zeroes every counter at that clock edge. This takes priority over an increment in the same cycle. The bit is not stored and always reads back as 0.
- R5: Bit i of the count-clock register at offset 0x4 makes counter i increment on every enabled clock edge, whatever its event line does.
- R6: Counter i's value is read at offset 0xC + 4*i, also while the bank is counting. Read data is registered: it appears on the bus one cycle after the read strobe and shows the count from before that edge's increment. A write to the same offset preloads the counter.
- R7: A counter that is not joined goes from 0xFFFFFFFF to 0 on its next increment, and its neighbour does not change.
- R8: Bit j of control bits 15:0 joins counters 2j and 2j+1. While pair j is joined, the odd counter increments exactly when the even counter wraps from 0xFFFFFFFF to 0, and the odd counter's own event and count-clock bit have no effect.
- R9: While pair j is joined, a read of counter 2j captures the current value of counter 2j+1. Later reads of counter 2j+1 return that captured value until the next read of counter 2j.
- R10: Reads of byte offsets that no register occupies return zero. Writes to such offsets change no register or counter.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr_i | input | 1 | Register write strobe |
| bus_rd_i | input | 1 | Register read strobe |
| bus_addr_i | input | ADDR_W | Byte offset of the register |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data, valid one cycle after bus_rd_i |
| event_i | input | NUM_EVT | Event lines, one increment per high cycle |

## Verification
The hardest cases to reach from the ports are the two carry paths. One is the unjoined wrap from all ones to zero. The other is the joined carry into the odd half, together with the high word captured for a split 64-bit read. Counting up to 2^32 is out of reach, so the bench preloads counters a few counts below the wrap through their value registers. It then drives a known number of event cycles and checks both halves. The odd half is rewritten between the two half-reads, which shows that the value returned came from the captured copy and not from the live counter.

// File: rtl/pcb_pkg.sv
package pcb_pkg;
  localparam int unsigned DATA_W   = 32;
  localparam int unsigned CTRL_OFS = 0;
  localparam int unsigned CCLK_OFS = 4;
  localparam int unsigned VAL_BASE = 12;
  localparam int unsigned SEL_BASE = 64;
  localparam int unsigned EN_BIT   = 30;
  localparam int unsigned CLR_BIT  = 28;
  localparam int unsigned JOIN_MAX = 16;

  function automatic int unsigned val_ofs(input int unsigned idx);
    return VAL_BASE + 4 * idx;
  endfunction

  function automatic int unsigned sel_ofs(input int unsigned idx);
    return SEL_BASE + 4 * idx;
  endfunction
endpackage

// File: rtl/pcb_regs.sv
module pcb_regs
  import pcb_pkg::*;
#(
  parameter int unsigned NUM_CNT = 8,
  parameter int unsigned EVT_W   = 4,
  parameter int unsigned ADDR_W  = 8,
  localparam int unsigned NUM_PAIR = NUM_CNT / 2
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            wr_en_i,
  input  logic [ADDR_W-1:0]               addr_i,
  input  logic [DATA_W-1:0]               wdata_i,
  output logic                            en_o,
  output logic                            clr_o,
  output logic [NUM_PAIR-1:0]             join_o,
  output logic [NUM_CNT-1:0]              cclk_o,
  output logic [NUM_CNT-1:0][EVT_W-1:0]   sel_o,
  output logic [NUM_CNT-1:0]              ld_o
);

  logic                          en_q, en_d;
  logic [NUM_PAIR-1:0]           join_q, join_d;
  logic [NUM_CNT-1:0]            cclk_q, cclk_d;
  logic [NUM_CNT-1:0][EVT_W-1:0] sel_q, sel_d;
  logic                          hit_ctrl, hit_cclk;
  logic                          unused_wdata;

  assign unused_wdata = ^wdata_i;
  assign hit_ctrl = wr_en_i && (addr_i == ADDR_W'(CTRL_OFS));
  assign hit_cclk = wr_en_i && (addr_i == ADDR_W'(CCLK_OFS));

  // Next-state decode
  always_comb begin
    en_d   = en_q;
    join_d = join_q;
    cclk_d = cclk_q;
    sel_d  = sel_q;
    ld_o   = '0;
    if (hit_ctrl) begin
      en_d   = wdata_i[EN_BIT];
      join_d = wdata_i[NUM_PAIR-1:0];
    end
    if (hit_cclk) cclk_d = wdata_i[NUM_CNT-1:0];
    for (int i = 0; i < NUM_CNT; i++) begin
      if (wr_en_i && (addr_i == ADDR_W'(sel_ofs(i)))) sel_d[i] = wdata_i[EVT_W-1:0];
      if (wr_en_i && (addr_i == ADDR_W'(val_ofs(i)))) ld_o[i] = 1'b1;
    end
  end

  // Clear is a pulse taken straight from the write; it is never stored
  assign clr_o = hit_ctrl && wdata_i[CLR_BIT];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= 1'b0;
      join_q <= '0;
      cclk_q <= '0;
      sel_q  <= '0;
    end else begin
      en_q   <= en_d;
      join_q <= join_d;
      cclk_q <= cclk_d;
      sel_q  <= sel_d;
    end
  end

  assign en_o   = en_q;
  assign join_o = join_q;
  assign cclk_o = cclk_q;
  assign sel_o  = sel_q;

  // R3: enable changes only through a control write
  p_enable_only_by_ctrl_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en_i && (addr_i == ADDR_W'(CTRL_OFS))) |=> $stable(en_q));
  // R8: join bits change only through a control write
  p_join_only_by_ctrl_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en_i && (addr_i == ADDR_W'(CTRL_OFS))) |=> $stable(join_q));
  // R10: at most one counter is preloaded per write
  p_single_load_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(ld_o));
endmodule

// File: rtl/pcb_counter.sv
module pcb_counter #(
  parameter int unsigned CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr_i,
  input  logic             ld_i,
  input  logic [CNT_W-1:0] ld_val_i,
  input  logic             inc_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             wrap_o
);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  // Priority: clear, then preload, then increment
  assign cnt_en = clr_i || ld_i || inc_i;

  always_comb begin
    cnt_d = cnt_q;
    if (clr_i)      cnt_d = '0;
    else if (ld_i)  cnt_d = ld_val_i;
    else if (inc_i) cnt_d = cnt_q + CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign cnt_o  = cnt_q;
  assign wrap_o = inc_i && !clr_i && !ld_i && (&cnt_q);

  // R4: clear wins over everything
  p_clear_wins_r4: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> (cnt_q == '0));
  // R2: an increment adds exactly one
  p_step_one_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (inc_i && !clr_i && !ld_i) |=> (cnt_q == $past(cnt_q) + CNT_W'(1)));
  // R3: idle counters hold
  p_hold_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!inc_i && !clr_i && !ld_i) |=> $stable(cnt_q));
  // R7: wrap lands on zero
  p_wrap_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
    wrap_o |=> (cnt_q == '0));
endmodule

// File: rtl/pcb_readback.sv
module pcb_readback
  import pcb_pkg::*;
#(
  parameter int unsigned NUM_CNT = 8,
  parameter int unsigned EVT_W   = 4,
  parameter int unsigned ADDR_W  = 8,
  localparam int unsigned NUM_PAIR = NUM_CNT / 2
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            rd_en_i,
  input  logic [ADDR_W-1:0]               addr_i,
  input  logic [NUM_CNT-1:0][DATA_W-1:0]  cnt_i,
  input  logic                            en_i,
  input  logic [NUM_PAIR-1:0]             join_i,
  input  logic [NUM_CNT-1:0]              cclk_i,
  input  logic [NUM_CNT-1:0][EVT_W-1:0]   sel_i,
  output logic [DATA_W-1:0]               rdata_o
);

  logic [NUM_PAIR-1:0][DATA_W-1:0] hi_q, hi_d;
  logic [NUM_PAIR-1:0]             lat_hit;
  logic [DATA_W-1:0]               rd_mux, rdata_q;

  // Word selection by offset; unmapped offsets give zero
  always_comb begin
    rd_mux = '0;
    if (addr_i == ADDR_W'(CTRL_OFS)) begin
      rd_mux[EN_BIT]         = en_i;
      rd_mux[NUM_PAIR-1:0]   = join_i;
    end
    if (addr_i == ADDR_W'(CCLK_OFS)) rd_mux[NUM_CNT-1:0] = cclk_i;
    for (int j = 0; j < NUM_PAIR; j++) begin
      if (addr_i == ADDR_W'(val_ofs(2 * j)))     rd_mux = cnt_i[2*j];
      if (addr_i == ADDR_W'(val_ofs(2 * j + 1))) rd_mux = join_i[j] ? hi_q[j] : cnt_i[2*j+1];
    end
    for (int i = 0; i < NUM_CNT; i++) begin
      if (addr_i == ADDR_W'(sel_ofs(i))) rd_mux[EVT_W-1:0] = sel_i[i];
    end
  end

  // High-word capture on low-word reads of joined pairs
  always_comb begin
    hi_d = hi_q;
    for (int j = 0; j < NUM_PAIR; j++) begin
      lat_hit[j] = rd_en_i && join_i[j] && (addr_i == ADDR_W'(val_ofs(2 * j)));
      if (lat_hit[j]) hi_d[j] = cnt_i[2*j+1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_q    <= '0;
      rdata_q <= '0;
    end else begin
      hi_q <= hi_d;
      if (rd_en_i) rdata_q <= rd_mux;
    end
  end

  assign rdata_o = rdata_q;

  // R9: the captured high word moves only on a low-word read
  for (genvar j = 0; j < NUM_PAIR; j++) begin : g_hi_chk
    p_hi_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !lat_hit[j] |=> $stable(hi_q[j]));
  end
  // R6: read data changes only after a read strobe
  p_rdata_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en_i |=> $stable(rdata_q));
endmodule

// File: rtl/perf_counter_bank.sv
module perf_counter_bank
  import pcb_pkg::*;
#(
  parameter int unsigned NUM_CNT = 8,
  parameter int unsigned NUM_EVT = 16,
  parameter int unsigned ADDR_W  = 8,
  localparam int unsigned NUM_PAIR = NUM_CNT / 2,
  localparam int unsigned EVT_W    = (NUM_EVT > 1) ? $clog2(NUM_EVT) : 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                bus_wr_i,
  input  logic                bus_rd_i,
  input  logic [ADDR_W-1:0]   bus_addr_i,
  input  logic [DATA_W-1:0]   bus_wdata_i,
  output logic [DATA_W-1:0]   bus_rdata_o,
  input  logic [NUM_EVT-1:0]  event_i
);

  logic                           en_w, clr_w;
  logic [NUM_PAIR-1:0]            join_w;
  logic [NUM_CNT-1:0]             cclk_w, ld_w, inc_w, wrap_w;
  logic [NUM_CNT-1:0][EVT_W-1:0]  sel_w;
  logic [NUM_CNT-1:0][DATA_W-1:0] cnt_w;

  pcb_regs #(.NUM_CNT(NUM_CNT), .EVT_W(EVT_W), .ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en_i(bus_wr_i), .addr_i(bus_addr_i),
    .wdata_i(bus_wdata_i), .en_o(en_w), .clr_o(clr_w), .join_o(join_w),
    .cclk_o(cclk_w), .sel_o(sel_w), .ld_o(ld_w)
  );

  for (genvar j = 0; j < NUM_PAIR; j++) begin : g_pair
    localparam int unsigned LO = 2 * j;
    localparam int unsigned HI = 2 * j + 1;

    assign inc_w[LO] = en_w && (cclk_w[LO] || event_i[sel_w[LO]]);
    // Joined odd half counts only the carry out of the even half
    assign inc_w[HI] = join_w[j] ? wrap_w[LO]
                                 : (en_w && (cclk_w[HI] || event_i[sel_w[HI]]));

    pcb_counter #(.CNT_W(DATA_W)) u_lo (
      .clk(clk), .rst_n(rst_n), .clr_i(clr_w), .ld_i(ld_w[LO]), .ld_val_i(bus_wdata_i),
      .inc_i(inc_w[LO]), .cnt_o(cnt_w[LO]), .wrap_o(wrap_w[LO])
    );
    pcb_counter #(.CNT_W(DATA_W)) u_hi (
      .clk(clk), .rst_n(rst_n), .clr_i(clr_w), .ld_i(ld_w[HI]), .ld_val_i(bus_wdata_i),
      .inc_i(inc_w[HI]), .cnt_o(cnt_w[HI]), .wrap_o(wrap_w[HI])
    );

    // R8: carry into a joined odd half
    p_carry_in_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (join_w[j] && wrap_w[LO] && !clr_w && !ld_w[HI])
        |=> (cnt_w[HI] == $past(cnt_w[HI]) + DATA_W'(1)));
    // R8: joined odd half ignores its own event while no carry arrives
    p_odd_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (join_w[j] && !wrap_w[LO] && !clr_w && !ld_w[HI]) |=> $stable(cnt_w[HI]));
    // R7: unjoined wrap never touches the neighbour without its own cause
    p_no_carry_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (!join_w[j] && wrap_w[LO] && !inc_w[HI] && !clr_w && !ld_w[HI])
        |=> $stable(cnt_w[HI]));
  end

  pcb_readback #(.NUM_CNT(NUM_CNT), .EVT_W(EVT_W), .ADDR_W(ADDR_W)) u_rd (
    .clk(clk), .rst_n(rst_n), .rd_en_i(bus_rd_i), .addr_i(bus_addr_i),
    .cnt_i(cnt_w), .en_i(en_w), .join_i(join_w), .cclk_i(cclk_w), .sel_i(sel_w),
    .rdata_o(bus_rdata_o)
  );
endmodule

// File: tb/perf_counter_bank_test.sv
module perf_counter_bank_test;
  localparam int CLK_PERIOD = 10;
  localparam logic [7:0] A_CTRL = 8'h00;
  localparam logic [7:0] A_CCLK = 8'h04;
  localparam logic [31:0] EN  = 32'h4000_0000;
  localparam logic [31:0] CLR = 32'h1000_0000;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        wr, rd;
  logic [7:0]  addr;
  logic [31:0] wdata, rdata;
  logic [15:0] ev;
  int          n_chk = 0, n_bad = 0;
  bit          done = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  perf_counter_bank uut (
    .clk(clk), .rst_n(rst_n), .bus_wr_i(wr), .bus_rd_i(rd), .bus_addr_i(addr),
    .bus_wdata_i(wdata), .bus_rdata_o(rdata), .event_i(ev)
  );

  function automatic logic [7:0] va(input int i); return 8'(12 + 4 * i); endfunction
  function automatic logic [7:0] sa(input int i); return 8'(64 + 4 * i); endfunction

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic wr_reg(input logic [7:0] a, input logic [31:0] d);
    wr = 1'b1; addr = a; wdata = d;
    @(posedge clk); @(negedge clk);
    wr = 1'b0;
  endtask

  task automatic rd_reg(input logic [7:0] a, output logic [31:0] d);
    rd = 1'b1; addr = a;
    @(posedge clk); @(negedge clk);
    rd = 1'b0; d = rdata;
  endtask

  task automatic pulse(input logic [15:0] m, input int n);
    ev = m;
    repeat (n) @(negedge clk);
    ev = '0;
  endtask

  task automatic t_reset;
    logic [31:0] d;
    rd_reg(A_CTRL, d); check("R1 ctrl", d, 0);
    rd_reg(A_CCLK, d); check("R1 cclk", d, 0);
    rd_reg(va(0), d);  check("R1 cnt0", d, 0);
    rd_reg(sa(0), d);  check("R1 sel0", d, 0);
  endtask

  task automatic t_events;
    logic [31:0] d;
    wr_reg(sa(0), 32'hFFFF_FFF3); wr_reg(sa(1), 5); wr_reg(sa(2), 3);
    wr_reg(A_CTRL, EN);
    pulse(16'h0008, 10); pulse(16'h0020, 4); pulse(16'h0028, 3);
    wr_reg(A_CTRL, 0);
    rd_reg(va(0), d); check("R2 cnt0", d, 13);
    rd_reg(va(1), d); check("R2 cnt1", d, 7);
    rd_reg(va(2), d); check("R2 cnt2", d, 13);
    rd_reg(va(3), d); check("R2 cnt3", d, 0);
    rd_reg(sa(0), d); check("R2 sel0 masked", d, 3);
  endtask

  task automatic t_disable;
    logic [31:0] d;
    pulse(16'h0008, 5);
    rd_reg(va(0), d); check("R3 hold while off", d, 13);
    wr_reg(A_CTRL, EN);
    rd_reg(A_CTRL, d); check("R3 enable readback", d, EN);
  endtask

  task automatic t_live_read;
    logic [31:0] a, b;
    ev = 16'h0008;
    rd_reg(va(0), a);
    rd_reg(va(0), b);
    ev = '0;
    check("R6 live read first", a, 13);
    check("R6 live read second", b, 14);
    wr_reg(va(5), 32'h1234_5678);
    rd_reg(va(5), a); check("R6 preload", a, 32'h1234_5678);
  endtask

  task automatic t_clear;
    logic [31:0] d;
    ev = 16'h0008;
    wr_reg(A_CTRL, EN | CLR);
    ev = '0;
    rd_reg(va(0), d); check("R4 clear beats inc", d, 0);
    rd_reg(va(5), d); check("R4 clear all", d, 0);
    rd_reg(A_CTRL, d); check("R4 clear reads 0", d, EN);
    wr_reg(A_CTRL, 0);
  endtask

  task automatic t_cycles;
    logic [31:0] d;
    wr_reg(A_CCLK, 32'h10);
    wr_reg(A_CTRL, EN);
    repeat (6) @(negedge clk);
    wr_reg(A_CTRL, 0);
    rd_reg(va(4), d); check("R5 cycle count", d, 7);
    rd_reg(va(5), d); check("R5 neighbour idle", d, 0);
    rd_reg(A_CCLK, d); check("R5 readback", d, 32'h10);
    wr_reg(A_CCLK, 0);
  endtask

  task automatic t_wrap;
    logic [31:0] d;
    wr_reg(va(0), 32'hFFFF_FFFE); wr_reg(va(1), 5);
    wr_reg(A_CTRL, EN);
    pulse(16'h0008, 3);
    wr_reg(A_CTRL, 0);
    rd_reg(va(0), d); check("R7 wrap", d, 1);
    rd_reg(va(1), d); check("R7 no carry", d, 5);
  endtask

  task automatic t_join;
    logic [31:0] d;
    wr_reg(sa(3), 3);
    wr_reg(va(2), 32'hFFFF_FFFE); wr_reg(va(3), 7);
    wr_reg(A_CTRL, 32'h2);
    rd_reg(A_CTRL, d); check("R8 join readback", d, 2);
    wr_reg(A_CTRL, EN | 32'h2);
    pulse(16'h0008, 5);
    wr_reg(A_CTRL, 32'h2);
    rd_reg(va(2), d); check("R8 low half", d, 3);
    rd_reg(va(3), d); check("R8 high half carry", d, 8);
  endtask

  task automatic t_coherent;
    logic [31:0] d;
    wr_reg(va(3), 100);
    rd_reg(va(3), d); check("R9 captured high", d, 8);
    rd_reg(va(2), d); check("R9 low reread", d, 3);
    rd_reg(va(3), d); check("R9 recapture", d, 100);
  endtask

  task automatic t_unmapped;
    logic [31:0] d;
    rd_reg(8'h08, d); check("R10 read 0x08", d, 0);
    rd_reg(8'h30, d); check("R10 read 0x30", d, 0);
    wr_reg(8'h08, 32'hFFFF_FFFF); wr_reg(8'h30, 32'hFFFF_FFFF);
    rd_reg(A_CTRL, d); check("R10 ctrl kept", d, 2);
    rd_reg(A_CCLK, d); check("R10 cclk kept", d, 0);
    rd_reg(va(0), d); check("R10 cnt0 kept", d, 6);
  endtask

  initial begin
    rst_n = 1'b0; wr = 1'b0; rd = 1'b0; addr = '0; wdata = '0; ev = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset;
    t_events;
    t_disable;
    t_live_read;
    t_clear;
    t_cycles;
    t_wrap;
    t_join;
    t_coherent;
    t_unmapped;
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 20000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule